// File: doc/BRIEF.md
# Line-Alternating Vertical Pattern Sequencer

This block drives up to eight vertical clock phases of a CCD timing generator, one pixel clock at a time. Each line starts with a line-start strobe. On that strobe the block selects one stored pattern group and replays it back to back a set number of times. The number of replays alternates between an odd-line count and an even-line count. The group itself is the same on odd and even lines. After the last replay all phases return to their inactive (low) level until the next line starts.

On the line that carries the sensor-gate pulses, the block can also emit a second pattern group. That group is chosen per field. It starts at a line position taken from the second group's own length field, which serves as a start offset rather than a length. Because of this, the second group plays once and never repeats. It takes over the outputs at that position, cutting short any primary replay still in progress, and it runs until the next line start.

Pattern tables are loaded through a valid/ready write port. A write is accepted on a clock edge where `tbl_valid` and `tbl_ready` are both high. `tbl_ready` is low whenever a pattern is playing, so the tables never change under a running pattern. A writer that sees `tbl_ready` low must hold its address and data until the handshake completes.

Top module: `vpat_line_seq`

## Requirements
- R1: A field start makes the next line odd. Every later line start flips the line parity. Odd lines replay the group `rep_odd` times and even lines replay it `rep_even` times.
- R2: A field start returns the outputs to all-low and stops any pattern. It also latches `grp2_sel` and `grp2_en`, and these latched values hold for the whole field.
- R3: On each line start the block latches `grp_sel` and `sg_line`. It then plays the selected group exactly N times in a row, with N given by the line parity. The same group is used on odd and even lines. When N is 0 the line produces no primary output.
- R4: Within a group of length L the pattern position runs from 0 to L-1 and then wraps for the next replay. Position 0 is the first cycle after the line-start edge. When phase p's set position equals the current position, `xv[p]` goes high on the next edge. When its clear position equals the current position, `xv[p]` goes low on the next edge. If both match, set wins.
- R5: Outside a playing pattern, including after reset and after the last replay (whose final position causes no toggle), every output is low.
- R6: Suppose `sg_line` was high at the line start and a second group is enabled. Then, on the edge where the line position (0 on the cycle after the line start) equals the second group's length field, all outputs clear and the second group begins at its position 0, cutting short any primary replay.
- R7: The second group plays once. Its position counts up and holds at its maximum. It never restarts before the next line start or field start.
- R8: A write is taken when `tbl_valid` and `tbl_ready` are both high.
  - The address is {group, slot} with a 4-bit slot.
  - Slots 0 to 7 hold phase p's set position in data[9:0] and its clear position in data[19:10].
  - Slot 8 holds the group length in data[9:0].
  - `tbl_ready` is low while any pattern plays, and a write offered then is not stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hd | input | 1 | Line-start strobe, one cycle |
| field_start | input | 1 | Field-start strobe, one cycle |
| sg_line | input | 1 | Marks the line starting with this `hd` as a sensor-gate line |
| rep_odd | input | 4 | Replay count for odd lines |
| rep_even | input | 4 | Replay count for even lines |
| grp_sel | input | 2 | Primary group, latched at line start |
| grp2_sel | input | 2 | Second group, latched at field start |
| grp2_en | input | 1 | Second-group enable, latched at field start |
| tbl_valid | input | 1 | Table write request |
| tbl_ready | output | 1 | Table write can be accepted |
| tbl_addr | input | 6 | {group, slot} |
| tbl_data | input | 20 | {clear position, set position} or length |
| xv | output | 8 | Registered vertical clock phases |

## Verification
The assertions take for granted the following:
- `hd` and `field_start` never arrive on the same cycle.
- Every group that is played with a nonzero replay count has a length of at least 1, so the position counter always stays below the length.

The stimulus keeps within these limits. Strobes come one at a time with a full line between line starts. All groups are loaded with nonzero lengths before the first field start. Tables are written only while the block is idle, apart from one deliberate write offered during playback to exercise back-pressure.

// File: rtl/vpat_pkg.sv
package vpat_pkg;
  typedef enum logic [1:0] {
    M_IDLE = 2'd0,
    M_PRI  = 2'd1,
    M_SEC  = 2'd2
  } seq_mode_e;
endpackage

// File: rtl/vpat_table.sv
module vpat_table #(
  parameter int NUM_PH = 8,
  parameter int NGRP   = 4,
  parameter int CW     = 10,
  parameter int GW     = 2,
  parameter int SW     = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [GW-1:0]        wr_grp,
  input  logic [SW-1:0]        wr_slot,
  input  logic [2*CW-1:0]      wr_data,
  input  logic [GW-1:0]        rd_grp,
  output logic [NUM_PH*CW-1:0] rd_set,
  output logic [NUM_PH*CW-1:0] rd_clr,
  input  logic [GW-1:0]        len_a_grp,
  output logic [CW-1:0]        len_a,
  input  logic [GW-1:0]        len_b_grp,
  output logic [CW-1:0]        len_b
);
  logic [CW-1:0] set_mem [NGRP][NUM_PH];
  logic [CW-1:0] clr_mem [NGRP][NUM_PH];
  logic [CW-1:0] len_mem [NGRP];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int g = 0; g < NGRP; g++) begin
        len_mem[g] <= '0;
        for (int p = 0; p < NUM_PH; p++) begin
          set_mem[g][p] <= '0;
          clr_mem[g][p] <= '0;
        end
      end
    end else if (wr_en) begin
      for (int g = 0; g < NGRP; g++) begin
        if (wr_grp == GW'(g)) begin
          if (wr_slot == SW'(NUM_PH)) len_mem[g] <= wr_data[CW-1:0];
          for (int p = 0; p < NUM_PH; p++) begin
            if (wr_slot == SW'(p)) begin
              set_mem[g][p] <= wr_data[CW-1:0];
              clr_mem[g][p] <= wr_data[2*CW-1:CW];
            end
          end
        end
      end
    end
  end

  for (genvar p = 0; p < NUM_PH; p++) begin : g_rd
    assign rd_set[p*CW +: CW] = set_mem[rd_grp][p];
    assign rd_clr[p*CW +: CW] = clr_mem[rd_grp][p];
  end

  assign len_a = len_mem[len_a_grp];
  assign len_b = len_mem[len_b_grp];
endmodule

// File: rtl/vpat_match.sv
module vpat_match #(
  parameter int NUM_PH = 8,
  parameter int CW     = 10
) (
  input  logic [CW-1:0]        pos,
  input  logic [NUM_PH*CW-1:0] set_pos,
  input  logic [NUM_PH*CW-1:0] clr_pos,
  output logic [NUM_PH-1:0]    set_hit,
  output logic [NUM_PH-1:0]    clr_hit
);
  for (genvar p = 0; p < NUM_PH; p++) begin : g_ph
    assign set_hit[p] = (set_pos[p*CW +: CW] == pos);
    assign clr_hit[p] = (clr_pos[p*CW +: CW] == pos);
  end
endmodule

// File: rtl/vpat_seq_ctl.sv
module vpat_seq_ctl
  import vpat_pkg::*;
#(
  parameter int CW = 10,
  parameter int RW = 4,
  parameter int GW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hd,
  input  logic          field_start,
  input  logic          sg_line,
  input  logic [RW-1:0] rep_odd,
  input  logic [RW-1:0] rep_even,
  input  logic [GW-1:0] grp_sel,
  input  logic [GW-1:0] grp2_sel,
  input  logic          grp2_en,
  input  logic [CW-1:0] len_pri,
  input  logic [CW-1:0] len_sec,
  output seq_mode_e     mode,
  output logic [CW-1:0] pos,
  output logic [GW-1:0] pri_grp,
  output logic [GW-1:0] sec_grp,
  output logic [GW-1:0] act_grp,
  output logic          sec_go,
  output logic          clear_out,
  output logic          line_odd
);
  logic [RW-1:0] reps_left;
  logic [CW-1:0] line_pos;
  logic          sg_q, g2en_q;
  logic          pri_last, pri_end;
  logic [RW-1:0] new_reps;

  always_comb begin
    pri_last  = (mode == M_PRI) && (pos == len_pri - CW'(1));
    sec_go    = sg_q && g2en_q && (mode != M_SEC) && (line_pos == len_sec);
    pri_end   = pri_last && (reps_left == RW'(1)) && !sec_go;
    clear_out = field_start || hd || sec_go || pri_end;
    new_reps  = line_odd ? rep_even : rep_odd;
    act_grp   = (mode == M_SEC) ? sec_grp : pri_grp;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode      <= M_IDLE;
      pos       <= '0;
      reps_left <= '0;
      line_pos  <= '0;
      line_odd  <= 1'b0;
      sg_q      <= 1'b0;
      g2en_q    <= 1'b0;
      pri_grp   <= '0;
      sec_grp   <= '0;
    end else if (field_start) begin
      mode      <= M_IDLE;
      pos       <= '0;
      reps_left <= '0;
      line_odd  <= 1'b0;
      sg_q      <= 1'b0;
      sec_grp   <= grp2_sel;
      g2en_q    <= grp2_en;
    end else if (hd) begin
      line_odd  <= ~line_odd;
      pri_grp   <= grp_sel;
      sg_q      <= sg_line;
      line_pos  <= '0;
      pos       <= '0;
      reps_left <= new_reps;
      mode      <= (new_reps != '0) ? M_PRI : M_IDLE;
    end else begin
      if (line_pos != '1) line_pos <= line_pos + CW'(1);
      if (sec_go) begin
        mode      <= M_SEC;
        pos       <= '0;
        reps_left <= '0;
      end else if (mode == M_PRI) begin
        if (pri_last) begin
          pos       <= '0;
          reps_left <= reps_left - RW'(1);
          if (reps_left == RW'(1)) mode <= M_IDLE;
        end else begin
          pos <= pos + CW'(1);
        end
      end else if (mode == M_SEC) begin
        if (pos != '1) pos <= pos + CW'(1);
      end
    end
  end

  AST_PARITY_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
    (hd && !field_start) |=> (line_odd != $past(line_odd))); // R1
  AST_FIELD_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    field_start |=> (!line_odd && mode == M_IDLE)); // R2
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_PRI) |-> (reps_left != '0)); // R3
  AST_POS_IN_GROUP: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_PRI) |-> (pos < len_pri)); // R4
  AST_SEC_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_SEC && !hd && !field_start) |=> (mode == M_SEC)); // R7
endmodule

// File: rtl/vpat_line_seq.sv
module vpat_line_seq
  import vpat_pkg::*;
#(
  parameter int NUM_PH = 8,
  parameter int NGRP   = 4,
  parameter int CW     = 10,
  parameter int RW     = 4,
  localparam int GW    = $clog2(NGRP),
  localparam int SW    = $clog2(NUM_PH + 1),
  localparam int AW    = GW + SW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hd,
  input  logic              field_start,
  input  logic              sg_line,
  input  logic [RW-1:0]     rep_odd,
  input  logic [RW-1:0]     rep_even,
  input  logic [GW-1:0]     grp_sel,
  input  logic [GW-1:0]     grp2_sel,
  input  logic              grp2_en,
  input  logic              tbl_valid,
  output logic              tbl_ready,
  input  logic [AW-1:0]     tbl_addr,
  input  logic [2*CW-1:0]   tbl_data,
  output logic [NUM_PH-1:0] xv
);
  seq_mode_e            mode;
  logic [CW-1:0]        pos, len_pri, len_sec;
  logic [GW-1:0]        pri_grp, sec_grp, act_grp;
  logic                 sec_go, clear_out, line_odd;
  logic [NUM_PH*CW-1:0] set_pos, clr_pos;
  logic [NUM_PH-1:0]    set_hit, clr_hit;

  assign tbl_ready = (mode == M_IDLE);

  vpat_table #(.NUM_PH(NUM_PH), .NGRP(NGRP), .CW(CW), .GW(GW), .SW(SW)) u_table (
    .clk(clk), .rst_n(rst_n),
    .wr_en(tbl_valid && tbl_ready),
    .wr_grp(tbl_addr[AW-1:SW]), .wr_slot(tbl_addr[SW-1:0]), .wr_data(tbl_data),
    .rd_grp(act_grp), .rd_set(set_pos), .rd_clr(clr_pos),
    .len_a_grp(pri_grp), .len_a(len_pri),
    .len_b_grp(sec_grp), .len_b(len_sec)
  );

  vpat_seq_ctl #(.CW(CW), .RW(RW), .GW(GW)) u_ctl (
    .clk(clk), .rst_n(rst_n), .hd(hd), .field_start(field_start), .sg_line(sg_line),
    .rep_odd(rep_odd), .rep_even(rep_even), .grp_sel(grp_sel),
    .grp2_sel(grp2_sel), .grp2_en(grp2_en),
    .len_pri(len_pri), .len_sec(len_sec),
    .mode(mode), .pos(pos), .pri_grp(pri_grp), .sec_grp(sec_grp), .act_grp(act_grp),
    .sec_go(sec_go), .clear_out(clear_out), .line_odd(line_odd)
  );

  vpat_match #(.NUM_PH(NUM_PH), .CW(CW)) u_match (
    .pos(pos), .set_pos(set_pos), .clr_pos(clr_pos),
    .set_hit(set_hit), .clr_hit(clr_hit)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               xv <= '0;
    else if (clear_out)       xv <= '0;
    else if (mode != M_IDLE)  xv <= (xv & ~clr_hit) | set_hit;
  end

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_IDLE) |-> (xv == '0)); // R5
  AST_SEC_TAKEOVER: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_go && !hd && !field_start) |=> (mode == M_SEC && xv == '0 && pos == '0)); // R6
  AST_WR_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_PRI || mode == M_SEC) |-> !tbl_ready); // R8
endmodule

// File: tb/vpat_line_seq_bench.sv
module vpat_line_seq_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic hd = 0, field_start = 0, sg_line = 0, grp2_en = 0, tbl_valid = 0;
  logic [3:0] rep_odd = 0, rep_even = 0;
  logic [1:0] grp_sel = 0, grp2_sel = 0;
  logic [5:0] tbl_addr = 0;
  logic [19:0] tbl_data = 0;
  logic tbl_ready;
  logic [7:0] xv;

  int n_checks = 0, n_fails = 0;
  string cur_req = "R5";
  bit model_on = 0;

  always #2.5 clk = ~clk;

  vpat_line_seq u_vpat_line_seq (
    .clk(clk), .rst_n(rst_n), .hd(hd), .field_start(field_start), .sg_line(sg_line),
    .rep_odd(rep_odd), .rep_even(rep_even), .grp_sel(grp_sel), .grp2_sel(grp2_sel),
    .grp2_en(grp2_en), .tbl_valid(tbl_valid), .tbl_ready(tbl_ready),
    .tbl_addr(tbl_addr), .tbl_data(tbl_data), .xv(xv)
  );

  // Behavioural reference: tables as integers, line state as plain variables.
  int t_set [4][8];
  int t_clr [4][8];
  int t_len [4];
  int m_mode, m_pos, m_reps, m_lpos, m_grp, m_g2, m_odd;
  bit m_sg, m_g2en;
  logic [7:0] m_xv;

  initial begin
    for (int g = 0; g < 4; g++) begin
      t_len[g] = 0;
      for (int p = 0; p < 8; p++) begin t_set[g][p] = 0; t_clr[g][p] = 0; end
    end
    m_mode = 0; m_pos = 0; m_reps = 0; m_lpos = 0; m_grp = 0; m_g2 = 0; m_odd = 0;
    m_sg = 0; m_g2en = 0; m_xv = 0;
  end

  always @(posedge clk) begin
    if (model_on) begin
      automatic bit acc = tbl_valid && (m_mode == 0);
      automatic int lp = t_len[m_grp];
      automatic int ls = t_len[m_g2];
      automatic bit go2 = m_sg && m_g2en && (m_mode != 2) && (m_lpos == ls);
      automatic int ag = (m_mode == 2) ? m_g2 : m_grp;
      if (field_start) begin
        m_mode = 0; m_pos = 0; m_reps = 0; m_odd = 0; m_sg = 0;
        m_g2 = grp2_sel; m_g2en = grp2_en; m_xv = 0;
      end else if (hd) begin
        m_odd = 1 - m_odd; m_grp = grp_sel; m_sg = sg_line; m_lpos = 0; m_pos = 0;
        m_reps = m_odd ? rep_odd : rep_even;
        m_mode = (m_reps != 0) ? 1 : 0; m_xv = 0;
      end else begin
        if (m_mode != 0)
          for (int p = 0; p < 8; p++) begin
            if (t_set[ag][p] == m_pos) m_xv[p] = 1'b1;
            else if (t_clr[ag][p] == m_pos) m_xv[p] = 1'b0;
          end
        if (go2) begin
          m_mode = 2; m_pos = 0; m_reps = 0; m_xv = 0;
        end else if (m_mode == 1) begin
          if (m_pos == lp - 1) begin
            m_pos = 0;
            if (m_reps == 1) begin m_mode = 0; m_xv = 0; end
            m_reps--;
          end else m_pos++;
        end else if (m_mode == 2) begin
          if (m_pos < 1023) m_pos++;
        end
        if (m_lpos < 1023) m_lpos++;
      end
      if (acc) begin
        if ((tbl_addr & 15) < 8) begin
          t_set[tbl_addr >> 4][tbl_addr & 15] = tbl_data[9:0];
          t_clr[tbl_addr >> 4][tbl_addr & 15] = tbl_data[19:10];
        end else if ((tbl_addr & 15) == 8) t_len[tbl_addr >> 4] = tbl_data[9:0];
      end
      #2;
      n_checks++;
      if (xv !== m_xv || tbl_ready !== (m_mode == 0)) begin
        n_fails++;
        $display("FAIL %s: xv=%h ready=%b expected xv=%h ready=%b", cur_req, xv, tbl_ready,
                 m_xv, (m_mode == 0));
      end
    end
  end

  task automatic tick(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(string req, logic [8:0] act, logic [8:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(int grp, int slot, int data);
    tbl_addr = 6'(grp * 16 + slot); tbl_data = 20'(data); tbl_valid = 1'b1;
    tick(); tbl_valid = 1'b0;
  endtask

  task automatic line(int len, bit sg = 0);
    hd = 1'b1; sg_line = sg; tick(); hd = 1'b0; sg_line = 1'b0; tick(len - 1);
  endtask

  task automatic fstart(int g2, bit en);
    grp2_sel = 2'(g2); grp2_en = en; field_start = 1'b1; tick(); field_start = 1'b0; tick();
  endtask

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick();
    check("R5 reset xv", {1'b0, xv}, 9'h0);
    check("R8 reset ready", {8'h0, tbl_ready}, 9'h1);
    model_on = 1;

    // R8: load tables through the handshake while idle.
    cur_req = "R8";
    for (int g = 0; g < 4; g++)
      for (int p = 0; p < 8; p++)
        wr(g, p, (((p + g + 3) % 7) << 10) | ((p + g) % 7));
    wr(1, 7, (1 << 10) | 1); // set and clear coincide: set wins (R4)
    wr(0, 8, 6);
    wr(1, 8, 4);
    wr(2, 8, 40);
    wr(3, 8, 20);

    // R1 / R3 / R4: odd 2 replays, even 5 replays of group 0.
    cur_req = "R1 R3 R4 odd/even replay";
    rep_odd = 2; rep_even = 5; grp_sel = 0;
    fstart(2, 1'b1);
    for (int i = 0; i < 4; i++) line(50);

    // R4: group with coinciding set/clear and short length.
    cur_req = "R4 group1 toggles";
    grp_sel = 1; rep_odd = 3; rep_even = 1;
    for (int i = 0; i < 2; i++) line(30);

    // R3: zero replays give a silent line.
    cur_req = "R3 zero replays";
    grp_sel = 0; rep_odd = 0; rep_even = 2;
    line(20);
    check("R3 silent odd line", {1'b0, xv}, 9'h0);
    line(20);

    // R6 / R7: second group on sensor-gate line after a finished primary.
    cur_req = "R6 R7 second group";
    rep_odd = 2; rep_even = 2;
    line(70, 1'b1);
    line(30);

    // R6: second group cuts short a primary still running (start 20, primary 30).
    cur_req = "R6 preempt";
    fstart(3, 1'b1);
    rep_odd = 5;
    line(60, 1'b1);

    // R2: grp2 inputs changed mid-field have no effect until next field start.
    cur_req = "R2 field latch";
    grp2_en = 1'b0; grp2_sel = 0;
    line(60, 1'b1);
    line(60, 1'b1);

    // R8: write offered while a pattern plays is held off and not stored.
    cur_req = "R8 back-pressure";
    hd = 1'b1; tick(); hd = 1'b0;
    tick(2);
    check("R8 ready low during pattern", {8'h0, tbl_ready}, 9'h0);
    tbl_addr = 6'(3 * 16 + 8); tbl_data = 20'd2; tbl_valid = 1'b1;
    tick(); tbl_valid = 1'b0;
    tick(40);
    line(60, 1'b1);

    // R2: field start mid-pattern clears outputs and restarts parity.
    cur_req = "R2 field restart";
    rep_odd = 4; rep_even = 1; grp_sel = 0;
    hd = 1'b1; tick(); hd = 1'b0; tick(4);
    grp2_en = 1'b0;
    field_start = 1'b1; tick(); field_start = 1'b0;
    check("R2 outputs cleared", {1'b0, xv}, 9'h0);
    tick();
    line(40); line(40); line(40, 1'b1);

    tick(5);
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_fails++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
    $finish;
  end
endmodule